// File: doc/BRIEF.md
# Posted CPU Write Buffer

This block sits between the host CPU bus and the display-memory / register access port. When posting is switched on, a CPU memory write is taken into a small first-in, first-out queue and acknowledged in the same cycle. The CPU does not wait for the memory cycle. Each queue stage keeps the address, the data word and the byte enables of one write. While the queue holds anything, the block asks the memory arbiter for a cycle. Each granted cycle retires exactly one entry, oldest first, on the downstream port.

Accesses that are not posted are passed through as direct downstream cycles once the queue is empty. These are CPU reads, CPU I/O-register writes, and memory writes while posting is off. This keeps reads and register writes strictly behind every earlier posted write. A stalled access asks the arbiter in the same cycle that the last queued entry is acknowledged. Clearing the posting enable while entries remain has no effect until the queue has drained. The downstream port holds its command stable from the first cycle of an access until the acknowledge.

Top module: `cpu_post_wbuf`

## Requirements
- R1: After reset, arb_req, dn_valid and cpu_rdy are all 0.
- R2: A CPU memory write (cpu_wr=1, cpu_io=0) is answered with cpu_rdy=1 in the cycle it is presented in both of these cases:
  - posting is enabled and fewer than DEPTH entries are queued;
  - the queue is full, in the cycle an entry retires.
- R3: Whenever the queue holds at least one entry and no downstream access is in progress, arb_req is 1.
- R4: Queued entries retire strictly in arrival order, one per granted cycle. Each appears on the downstream port with dn_wr=1, dn_io=0 and the captured address, data and byte enables.
- R5: With DEPTH entries queued, a new CPU memory write sees cpu_rdy=0 until the cycle in which an entry's dn_ack is 1. In that cycle cpu_rdy is 1.
- R6: A CPU read (cpu_wr=0) is not started downstream while any entry is queued. It raises arb_req in the same cycle as the dn_ack of the last queued entry. It completes after all earlier posted writes.
- R7: A CPU I/O write (cpu_wr=1, cpu_io=1) is not started downstream while any entry is queued. It reaches the downstream port with dn_io=1, after all earlier posted writes.
- R8: With posting disabled and the queue empty, a CPU memory write is a direct downstream access. Its cpu_rdy is 1 only in the cycle of its dn_ack.
- R9: Clearing post_en while entries are queued leaves posting in force: memory writes are still answered with zero wait until the queue is empty.
- R10: For a direct access, cpu_rdy is 1 exactly in the dn_ack cycle, and cpu_rdata equals dn_rdata in that cycle.
- R11: While dn_valid=1 and dn_ack=0, dn_valid stays 1 on the next cycle and dn_addr, dn_wdata, dn_be, dn_wr and dn_io do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Posting enable (takes effect off only after drain) |
| cpu_req | input | 1 | CPU access request, held until cpu_rdy |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_io | input | 1 | 1 = I/O register space, 0 = display memory |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_be | input | DATA_W/8 | CPU byte enables |
| cpu_rdy | output | 1 | Access complete this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_rdy of a read |
| arb_req | output | 1 | Request for a memory cycle |
| arb_gnt | input | 1 | Arbiter grant, sampled with arb_req |
| dn_valid | output | 1 | Downstream access in progress |
| dn_wr | output | 1 | Downstream write flag |
| dn_io | output | 1 | Downstream I/O space flag |
| dn_addr | output | ADDR_W | Downstream address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_be | output | DATA_W/8 | Downstream byte enables |
| dn_ack | input | 1 | Downstream access completion |
| dn_rdata | input | DATA_W | Downstream read data |

## Verification
The hardest case to reach is the moment a stalled read or I/O write is released. That is the single cycle in which the last queued entry is acknowledged, and arb_req must already be up for the waiting access. The bench gets there with a slow memory model and back-to-back posted writes. Writes are queued faster than they retire, so a read presented next is certain to find entries pending. In each cycle the bench compares the acknowledge count with the number of queued writes. The full-queue stall uses a withheld grant to fill all stages, then releases the grant in parallel with a fifth write. This shows that ready arrives exactly on a retire acknowledge.

// File: rtl/wbuf_pkg.sv
// Package: shared types of the posted write buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package wbuf_pkg;

    // Downstream sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RETIRE = 2'd1,
        ST_DIRECT = 2'd2
    } wbuf_state_e;

endpackage

// File: rtl/wbuf_fifo.sv
// Module: wbuf_fifo
// Stores posted write entries in arrival order and presents the oldest.
// Assumes: the caller never pushes when full unless it pops in the same cycle,
// and never pops when empty.
module wbuf_fifo #(
    parameter int WIDTH = 52,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wr_entry,
    output logic [WIDTH-1:0] head_entry,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Storage: one register per stage, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (push && (wr_ptr == PTR_W'(i))) begin
                slot[i] <= wr_entry;
            end
        end
    end

    // Pointer advance with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head selection and full flag.
    always_comb begin
        head_entry = slot[rd_ptr];
        full       = (count == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/wbuf_decode.sv
// Module: wbuf_decode
// Classifies the pending CPU request as posted or direct.
// Assumes: posting stays in force while any entry is queued, so clearing the
// enable only matters once the queue is empty.
module wbuf_decode (
    input  logic cpu_req,
    input  logic cpu_wr,
    input  logic cpu_io,
    input  logic post_en,
    input  logic occupied,
    output logic is_post,
    output logic is_direct
);

    // Memory writes post when enabled or while the queue still drains.
    always_comb begin
        is_post   = cpu_req && cpu_wr && !cpu_io && (post_en || occupied);
        is_direct = cpu_req && !is_post;
    end

endmodule

// File: rtl/wbuf_seq.sv
// Module: wbuf_seq
// Owns the downstream port: requests arbiter cycles, retires queue entries
// one per grant and runs direct accesses once the queue is empty.
// Assumes: arb_gnt is only meaningful while arb_req is high; dn_ack arrives
// only while an access is in progress.
module wbuf_seq
    import wbuf_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             is_direct,
    input  logic             arb_gnt,
    input  logic             dn_ack,
    output logic             arb_req,
    output logic             pop,
    output wbuf_state_e      state
);

    wbuf_state_e      state_nx;
    logic             slot_free;
    logic [CNT_W-1:0] left;
    logic             want_retire;
    logic             want_direct;

    // Cycle decisions: free slot, remaining entries, what to ask for next.
    always_comb begin
        pop         = (state == ST_RETIRE) && dn_ack;
        slot_free   = (state == ST_IDLE) || dn_ack;
        left        = count - CNT_W'(pop);
        want_retire = (left != '0);
        want_direct = is_direct && (left == '0) && (state != ST_DIRECT);
        arb_req     = slot_free && (want_retire || want_direct);
        state_nx    = state;
        if (slot_free) begin
            if (arb_gnt && want_retire)      state_nx = ST_RETIRE;
            else if (arb_gnt && want_direct) state_nx = ST_DIRECT;
            else                             state_nx = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/cpu_post_wbuf.sv
// Module: cpu_post_wbuf
// Posted CPU write buffer: queues memory writes with zero wait, retires them
// in order through arbiter-granted cycles, and holds reads and I/O writes
// until the queue is empty.
// Assumes: the CPU holds cpu_req and all request fields until cpu_rdy.
module cpu_post_wbuf
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int ENT_W = ADDR_W + DATA_W + BE_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_en,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              cpu_io,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              dn_valid,
    output logic              dn_wr,
    output logic              dn_io,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [BE_W-1:0]   dn_be,
    input  logic              dn_ack,
    input  logic [DATA_W-1:0] dn_rdata
);

    logic              q_push;
    logic              q_pop;
    logic              q_full;
    logic [CNT_W-1:0]  q_count;
    logic [ENT_W-1:0]  q_head;
    logic              is_post;
    logic              is_direct;
    logic              dir_sel;
    wbuf_state_e       seq_state;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [BE_W-1:0]   head_be;

    wbuf_decode u_decode (
        .cpu_req   (cpu_req),
        .cpu_wr    (cpu_wr),
        .cpu_io    (cpu_io),
        .post_en   (post_en),
        .occupied  (q_count != '0),
        .is_post   (is_post),
        .is_direct (is_direct)
    );

    wbuf_fifo #(
        .WIDTH (ENT_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .pop        (q_pop),
        .wr_entry   ({cpu_addr, cpu_wdata, cpu_be}),
        .head_entry (q_head),
        .count      (q_count),
        .full       (q_full)
    );

    wbuf_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (q_count),
        .is_direct (is_direct),
        .arb_gnt   (arb_gnt),
        .dn_ack    (dn_ack),
        .arb_req   (arb_req),
        .pop       (q_pop),
        .state     (seq_state)
    );

    // Accept a posted write when a stage is free or one retires this cycle.
    always_comb begin
        q_push  = is_post && (!q_full || q_pop);
        dir_sel = (seq_state == ST_DIRECT);
        cpu_rdy = q_push || (dir_sel && dn_ack);
    end

    // Downstream command: queue head for retires, CPU fields for direct access.
    always_comb begin
        {head_addr, head_data, head_be} = q_head;
        dn_valid  = (seq_state != ST_IDLE);
        dn_wr     = dir_sel ? cpu_wr    : 1'b1;
        dn_io     = dir_sel ? cpu_io    : 1'b0;
        dn_addr   = dir_sel ? cpu_addr  : head_addr;
        dn_wdata  = dir_sel ? cpu_wdata : head_data;
        dn_be     = dir_sel ? cpu_be    : head_be;
        cpu_rdata = dn_rdata;
    end

endmodule

// File: rtl/wbuf_checker.sv
// Module: wbuf_checker
// Temporal properties of the posted write buffer, bound to cpu_post_wbuf.
// Assumes: the CPU holds its request fields until cpu_rdy.
module wbuf_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              post_en,
    input logic              cpu_req,
    input logic              cpu_wr,
    input logic              cpu_io,
    input logic              cpu_rdy,
    input logic              arb_req,
    input logic              dn_valid,
    input logic              dn_wr,
    input logic              dn_io,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_wdata,
    input logic [BE_W-1:0]   dn_be,
    input logic              dn_ack,
    input logic [CNT_W-1:0]  count,
    input logic              full,
    input logic              push,
    input logic              pop
);

    // R2: zero-wait acceptance of an enabled memory write with a free stage.
    assert_zero_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_wr && !cpu_io && post_en && (count < CNT_W'(DEPTH))) |-> cpu_rdy);

    // R3: pending entries with an idle port always request a cycle.
    assert_req_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((count != '0) && !dn_valid) |-> arb_req);

    // R4: a retire is a plain memory write completed by an acknowledge.
    assert_retire_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (dn_ack && dn_wr && !dn_io));

    // R5: no stage is overwritten while the queue is full.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R6: reads never run downstream ahead of queued writes.
    assert_read_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_wr) |-> (count == '0));

    // R7: I/O writes never run downstream ahead of queued writes.
    assert_io_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_io) |-> (count == '0));

    // R8: with posting off and nothing queued, a write waits for the port.
    assert_direct_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_wr && !post_en && (count == '0) && !dn_valid) |-> !cpu_rdy);

    // R9: posting persists while the queue drains.
    assert_post_while_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_wr && !cpu_io && (count != '0) && (count < CNT_W'(DEPTH))) |-> cpu_rdy);

    // R11: downstream command is held until acknowledged.
    assert_hold_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr) && $stable(dn_wdata)
                                   && $stable(dn_be) && $stable(dn_wr) && $stable(dn_io)));

endmodule

bind cpu_post_wbuf wbuf_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_en  (post_en),
    .cpu_req  (cpu_req),
    .cpu_wr   (cpu_wr),
    .cpu_io   (cpu_io),
    .cpu_rdy  (cpu_rdy),
    .arb_req  (arb_req),
    .dn_valid (dn_valid),
    .dn_wr    (dn_wr),
    .dn_io    (dn_io),
    .dn_addr  (dn_addr),
    .dn_wdata (dn_wdata),
    .dn_be    (dn_be),
    .dn_ack   (dn_ack),
    .count    (q_count),
    .full     (q_full),
    .push     (q_push),
    .pop      (q_pop)
);

// File: tb/tb_cpu_post_wbuf.sv
// Bench: directed scenarios for cpu_post_wbuf, one task per scenario.
module tb_cpu_post_wbuf;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          post_en = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_wr = 1'b0;
    logic          cpu_io = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [BW-1:0] cpu_be = '0;
    logic          cpu_rdy;
    logic [DW-1:0] cpu_rdata;
    logic          arb_req;
    logic          arb_gnt = 1'b0;
    logic          dn_valid;
    logic          dn_wr;
    logic          dn_io;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata;
    logic [BW-1:0] dn_be;
    logic          dn_ack = 1'b0;
    logic [DW-1:0] dn_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    int            mem_lat = 1;
    int            wc = 0;
    bit            first_seen = 0;
    logic [AW-1:0] first_addr;
    logic [DW-1:0] first_data;
    int            n_log = 0;
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    logic [BW-1:0] log_be   [64];
    logic          log_wr   [64];
    logic          log_io   [64];

    cpu_post_wbuf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .post_en(post_en),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_io(cpu_io),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
        .arb_req(arb_req), .arb_gnt(arb_gnt),
        .dn_valid(dn_valid), .dn_wr(dn_wr), .dn_io(dn_io),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_be(dn_be),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign dn_rdata = {~dn_addr, dn_addr};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    // Memory model: acknowledges after mem_lat cycles, logs each access.
    always @(negedge clk) begin
        if (!rst_n) begin
            dn_ack <= 1'b0;
            wc = 0;
            first_seen = 0;
        end else if (dn_ack) begin
            dn_ack <= 1'b0;
            wc = 0;
            first_seen = 0;
        end else if (dn_valid) begin
            if (!first_seen) begin
                first_addr = dn_addr;
                first_data = dn_wdata;
                first_seen = 1;
            end
            if (wc >= mem_lat) begin
                dn_ack <= 1'b1;
                chk("R11 command held", {dn_addr, dn_wdata}, {first_addr, first_data});
                log_addr[n_log] = dn_addr;
                log_data[n_log] = dn_wdata;
                log_be[n_log]   = dn_be;
                log_wr[n_log]   = dn_wr;
                log_io[n_log]   = dn_io;
                n_log++;
            end else begin
                wc++;
            end
        end
    end

    // One CPU access; returns wait cycles, read data and dn_ack at ready.
    // rel_at >= 0: check arb_req in the cycle the log reaches rel_at entries.
    task automatic cpu_do(input logic wr, input logic io, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [BW-1:0] be, input int rel_at,
                          output int waits, output logic [DW-1:0] rd, output logic ack_at);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_io = io;
        cpu_addr = a; cpu_wdata = d; cpu_be = be;
        waits = 0;
        forever begin
            #2;
            if (rel_at >= 0 && dn_ack && n_log == rel_at && log_wr[n_log-1] && !log_io[n_log-1])
                chk("R6 release with last ack", {63'd0, arb_req}, 64'd1);
            if (cpu_rdy) break;
            if (waits > 200) break;
            @(negedge clk);
            waits++;
        end
        rd = cpu_rdata;
        ack_at = dn_ack;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 500 && n_log < n; i++) @(negedge clk);
        chk("R4 drain count", n_log, n);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_entry(input string req, input int idx, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic [BW-1:0] be,
                             input logic wr, input logic io);
        chk(req, {log_addr[idx], log_data[idx]}, {a, d});
        chk(req, {log_be[idx], log_wr[idx], log_io[idx]}, {be, wr, io});
    endtask

    task automatic t_reset();
        #2;
        chk("R1 reset arb_req", {63'd0, arb_req}, 64'd0);
        chk("R1 reset dn_valid", {63'd0, dn_valid}, 64'd0);
        chk("R1 reset cpu_rdy", {63'd0, cpu_rdy}, 64'd0);
    endtask

    task automatic t_post_order();
        int w; logic [DW-1:0] rd; logic ak; int base;
        base = n_log;
        post_en = 1'b1; arb_gnt = 1'b0; mem_lat = 1;
        for (int i = 0; i < 3; i++) begin
            cpu_do(1'b1, 1'b0, AW'(16'h1000 + i), DW'(32'hA0A0_0000 + i), BW'(4'h1 << i), -1, w, rd, ak);
            chk("R2 zero wait", w, 0);
        end
        #2;
        chk("R3 request while pending", {63'd0, arb_req}, 64'd1);
        chk("R3 nothing started without grant", {63'd0, dn_valid}, 64'd0);
        arb_gnt = 1'b1;
        wait_log(base + 3);
        for (int i = 0; i < 3; i++)
            chk_entry("R4 order", base + i, AW'(16'h1000 + i), DW'(32'hA0A0_0000 + i), BW'(4'h1 << i), 1'b1, 1'b0);
    endtask

    task automatic t_full();
        int w; logic [DW-1:0] rd; logic ak; int base;
        base = n_log;
        post_en = 1'b1; arb_gnt = 1'b0; mem_lat = 2;
        for (int i = 0; i < 4; i++) begin
            cpu_do(1'b1, 1'b0, AW'(16'h2000 + i), DW'(32'hB0B0_0000 + i), 4'hF, -1, w, rd, ak);
            chk("R2 zero wait to full", w, 0);
        end
        fork
            cpu_do(1'b1, 1'b0, 16'h2004, 32'hB0B0_0004, 4'h3, -1, w, rd, ak);
            begin repeat (6) @(negedge clk); arb_gnt = 1'b1; end
        join
        chk("R5 stalled while full", {63'd0, w > 5}, 64'd1);
        chk("R5 ready on retire ack", {63'd0, ak}, 64'd1);
        wait_log(base + 5);
        for (int i = 0; i < 4; i++)
            chk_entry("R4 order after full", base + i, AW'(16'h2000 + i), DW'(32'hB0B0_0000 + i), 4'hF, 1'b1, 1'b0);
        chk_entry("R5 stalled write kept", base + 4, 16'h2004, 32'hB0B0_0004, 4'h3, 1'b1, 1'b0);
    endtask

    task automatic t_read_stall();
        int w; logic [DW-1:0] rd; logic ak; int base;
        base = n_log;
        post_en = 1'b1; arb_gnt = 1'b1; mem_lat = 6;
        cpu_do(1'b1, 1'b0, 16'h3000, 32'hC0C0_0000, 4'hF, -1, w, rd, ak);
        cpu_do(1'b1, 1'b0, 16'h3001, 32'hC0C0_0001, 4'hC, -1, w, rd, ak);
        cpu_do(1'b0, 1'b0, 16'h3abc, 32'h0, 4'hF, base + 2, w, rd, ak);
        chk("R6 read waited", {63'd0, w > 8}, 64'd1);
        chk("R10 read data", rd, {~16'h3abc, 16'h3abc});
        chk("R10 ready on ack", {63'd0, ak}, 64'd1);
        chk("R6 read after writes", n_log, base + 3);
        chk_entry("R6 last is read", base + 2, 16'h3abc, 32'h0, 4'hF, 1'b0, 1'b0);
        chk_entry("R4 first write", base, 16'h3000, 32'hC0C0_0000, 4'hF, 1'b1, 1'b0);
    endtask

    task automatic t_io_stall();
        int w; logic [DW-1:0] rd; logic ak; int base;
        base = n_log;
        post_en = 1'b1; arb_gnt = 1'b1; mem_lat = 5;
        cpu_do(1'b1, 1'b0, 16'h4000, 32'hD0D0_0000, 4'hF, -1, w, rd, ak);
        cpu_do(1'b1, 1'b1, 16'h03c4, 32'h0000_0055, 4'h1, -1, w, rd, ak);
        chk("R7 io write waited", {63'd0, w > 4}, 64'd1);
        chk("R7 io ready on ack", {63'd0, ak}, 64'd1);
        chk_entry("R7 write first", base, 16'h4000, 32'hD0D0_0000, 4'hF, 1'b1, 1'b0);
        chk_entry("R7 io after", base + 1, 16'h03c4, 32'h0000_0055, 4'h1, 1'b1, 1'b1);
    endtask

    task automatic t_disable();
        int w; logic [DW-1:0] rd; logic ak; int base;
        base = n_log;
        post_en = 1'b1; arb_gnt = 1'b0; mem_lat = 1;
        cpu_do(1'b1, 1'b0, 16'h5000, 32'hE0E0_0000, 4'hF, -1, w, rd, ak);
        cpu_do(1'b1, 1'b0, 16'h5001, 32'hE0E0_0001, 4'hF, -1, w, rd, ak);
        post_en = 1'b0;
        cpu_do(1'b1, 1'b0, 16'h5002, 32'hE0E0_0002, 4'h6, -1, w, rd, ak);
        chk("R9 still posted while draining", w, 0);
        arb_gnt = 1'b1;
        wait_log(base + 3);
        chk_entry("R9 drained entry", base + 2, 16'h5002, 32'hE0E0_0002, 4'h6, 1'b1, 1'b0);
        cpu_do(1'b1, 1'b0, 16'h5003, 32'hE0E0_0003, 4'h9, -1, w, rd, ak);
        chk("R8 direct write waits", {63'd0, w > 0}, 64'd1);
        chk("R8 ready on ack", {63'd0, ak}, 64'd1);
        chk("R8 direct reached port", n_log, base + 4);
        chk_entry("R8 direct fields", base + 3, 16'h5003, 32'hE0E0_0003, 4'h9, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_post_order();
        t_full();
        t_read_stall();
        t_io_stall();
        t_disable();
        repeat (5) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule